// File: doc/BRIEF.md
# NAND Flash Device Command Interface

This block is a device-side model of a NAND flash part that sits behind an 8-bit bus. A host presents a byte on `din` together with a one-cycle `wr_stb`. The level of `cle` and `ale` marks that byte as a command, an address byte or a data byte. Bytes are accepted only while `ce_n` is low. A one-cycle `rd_stb` fetches the next output byte, which can be an identification byte, the status byte or array data. The memory is a small on-chip array of pages. Every page carries a spare area of one thirty-second of its main size.

One parameter selects the page format. Small-page format takes three address bytes for reads and programs: the column, then the page number low byte, then the high byte. Large-page format takes four: a 16-bit column, then a 16-bit page number. Address bytes arrive least significant first. Programming fills an internal page buffer. The program confirm then copies that buffer into the array, one byte per cycle. Erase sets a whole block to 0xFF, one byte per cycle. While either copy runs, the busy bit of the status byte is set.

Top module: `nand_flash_dev`

## Requirements
- R1: After `rst`, a read strobe returns 0x00. A status read returns 0x80 while `wp_n` is high. Status layout: bit 7 = `wp_n` level, bit 6 = busy, bit 0 = error, all other bits 0.
- R2: Every write strobe and read strobe taken while `ce_n` is high is ignored and changes no state. Such a read returns 0x00 and does not advance the read pointer.
- R3: Command 0x90 followed by one address byte makes the next four reads return the manufacturer ID, the device ID, 0xA5, and then 0x15 (large-page) or 0xC0 (small-page). Later reads return 0x00.
- R4: Command 0x00 followed by the full address (3 bytes small-page, 4 bytes large-page) starts a read at the column of the addressed page. The read returns one byte per strobe, for (page + spare − start) strobes, and 0x00 after that. A page number beyond the array yields 0x00.
- R5: Command 0x01 presets a start offset of 0x100, and command 0x50 presets an offset of the page size, which is the spare area. The offset is added to the column of the next completed address, after which it returns to 0. Command 0x00 clears it.
- R6: In large-page format, a 0x30 byte that arrives while the read command is active is ignored, and a read in progress continues.
- R7: Command 0x80, the address, up to page+spare data bytes, and then 0x10 with `wp_n` high write the data from the start column onward. Bytes past the end of the page are dropped, and all other bytes keep their values.
- R8: Command 0x60, the page number (2 bytes, LSB first) and then 0xD0 with `wp_n` high set every byte of the block that holds that page to 0xFF, spare included. Other blocks are left unchanged.
- R9: A program or erase confirm given while `wp_n` is low leaves the array unchanged and sets status bit 0.
- R10: Status bit 6 is high from the cycle after an accepted confirm until the copy or erase completes.
- R11: Command 0xFF clears the error bit, cancels any pending read or program, and returns to the read command state.
- R12: The array powers up with every byte at 0xFF.
- R13: `dout` changes only in the cycle after a read strobe, and then holds its value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Byte on `din` is a command |
| ale | input | 1 | Byte on `din` is an address byte |
| wp_n | input | 1 | Write protect, active low |
| wr_stb | input | 1 | One-cycle strobe taking `din` |
| rd_stb | input | 1 | One-cycle strobe fetching the next output byte |
| din | input | 8 | Bus byte from the host |
| dout | output | 8 | Byte returned by the last read strobe |

## Verification
The assertions assume that the host never raises `wr_stb` and `rd_stb` in the same cycle, and never raises `cle` and `ale` together. They also assume that no program or erase traffic arrives while the busy bit is set. Each bench task drives exactly one strobe per transfer and separates transfers with an idle cycle. After every confirm, the bench polls the status byte until bit 6 clears, so the copy engine is idle before the next operation.

// File: rtl/nand_pkg.sv
package nand_pkg;
  localparam logic [7:0] OP_READ_A     = 8'h00;
  localparam logic [7:0] OP_READ_B     = 8'h01;
  localparam logic [7:0] OP_READ_SPARE = 8'h50;
  localparam logic [7:0] OP_READ_GO    = 8'h30;
  localparam logic [7:0] OP_IDENT      = 8'h90;
  localparam logic [7:0] OP_RESET      = 8'hFF;
  localparam logic [7:0] OP_PROG       = 8'h80;
  localparam logic [7:0] OP_PROG_GO    = 8'h10;
  localparam logic [7:0] OP_ERASE      = 8'h60;
  localparam logic [7:0] OP_ERASE_GO   = 8'hD0;
  localparam logic [7:0] OP_STATUS     = 8'h70;

  localparam logic [7:0] IDENT_FILL  = 8'hA5;
  localparam logic [7:0] IDENT_LARGE = 8'h15;
  localparam logic [7:0] IDENT_SMALL = 8'hC0;

  typedef enum logic [1:0] {SRC_NONE, SRC_IDENT, SRC_STATUS, SRC_ARRAY} rd_src_e;
endpackage

// File: rtl/nand_ram.sv
module nand_ram #(
  parameter int DEPTH = 64,
  parameter int AW = 6,
  parameter logic [7:0] INIT = 8'hFF
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    q
);
  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = INIT;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/nand_commit_engine.sv
module nand_commit_engine #(
  parameter int AW = 12,
  parameter int CW = 11,
  parameter int BW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          erase_mode,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] count,
  input  logic [7:0]    buf_q,
  output logic          busy,
  output logic          buf_re,
  output logic [BW-1:0] buf_raddr,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata
);
  logic          run_q, mode_q, pv_q;
  logic [CW-1:0] idx_q, cnt_q;
  logic [AW-1:0] base_q, paddr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      mode_q  <= 1'b0;
      pv_q    <= 1'b0;
      idx_q   <= '0;
      cnt_q   <= '0;
      base_q  <= '0;
      paddr_q <= '0;
    end else begin
      pv_q    <= run_q;
      paddr_q <= base_q + AW'(idx_q);
      if (!run_q) begin
        if (start && count != '0) begin
          run_q  <= 1'b1;
          mode_q <= erase_mode;
          idx_q  <= '0;
          cnt_q  <= count;
          base_q <= base;
        end
      end else begin
        idx_q <= idx_q + 1'b1;
        if (idx_q + 1'b1 == cnt_q) run_q <= 1'b0;
      end
    end
  end

  assign busy      = run_q | pv_q;
  assign buf_re    = run_q & ~mode_q;
  assign buf_raddr = BW'(idx_q);
  assign mem_we    = pv_q;
  assign mem_waddr = paddr_q;
  assign mem_wdata = mode_q ? 8'hFF : buf_q;
endmodule

// File: rtl/nand_flash_dev.sv
module nand_flash_dev
  import nand_pkg::*;
#(
  parameter int PAGE_BYTES = 512,
  parameter bit LARGE_PAGE = 1'b0,
  parameter int PAGES_PER_BLOCK = 2,
  parameter int NUM_BLOCKS = 2,
  parameter logic [7:0] MFR_ID = 8'hEC,
  parameter logic [7:0] DEV_ID = 8'h73
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       wp_n,
  input  logic       wr_stb,
  input  logic       rd_stb,
  input  logic [7:0] din,
  output logic [7:0] dout
);
  localparam int SPARE  = PAGE_BYTES / 32;
  localparam int PS     = PAGE_BYTES + SPARE;
  localparam int NPAGES = PAGES_PER_BLOCK * NUM_BLOCKS;
  localparam int DEPTH  = NPAGES * PS;
  localparam int BLK    = PAGES_PER_BLOCK * PS;
  localparam int AW     = $clog2(DEPTH);
  localparam int BW     = $clog2(PS);
  localparam int LW     = $clog2(PS + 1);
  localparam int CW     = $clog2(BLK + 1);
  localparam int SW     = 18;
  localparam int ASHIFT = LARGE_PAGE ? 16 : 8;
  localparam int FIRE   = LARGE_PAGE ? 4 : 3;

  logic [7:0]    cmd_q;
  logic [31:0]   addr_q;
  logic [2:0]    acnt_q;
  logic [SW-1:0] off_q;
  logic [AW-1:0] rptr_q;
  logic [LW-1:0] rlen_q;
  rd_src_e       src_q;
  logic [1:0]    id_idx_q;
  logic          err_q;
  logic [LW-1:0] plen_q;
  logic [SW-1:0] pstart_q;
  logic [31:0]   prow_q;
  logic          armed_q;
  logic          out_arr_q;
  logic [7:0]    obyte_q;

  logic          bus_cmd, bus_adr, bus_dat, ignore_go;
  logic [31:0]   addr_nx, row_nx;
  logic [2:0]    cnt_nx;
  logic [SW-1:0] start_nx;
  logic          fire, row_ok;
  logic [AW-1:0] rd_base;
  logic [LW-1:0] rd_len_nx;
  logic          conf_prog, conf_erase, eng_start;
  logic [AW-1:0] p_base, e_base, eng_base;
  logic [LW-1:0] p_avail, p_cnt;
  logic [CW-1:0] eng_cnt;
  logic [7:0]    status, id_byte, arr_q, buf_q;
  logic          eng_busy, buf_re, arr_re, buf_we, mem_we;
  logic [BW-1:0] buf_raddr;
  logic [AW-1:0] mem_waddr;
  logic [7:0]    mem_wdata;

  // Bus decode
  assign bus_cmd   = wr_stb & ~ce_n & cle;
  assign bus_adr   = wr_stb & ~ce_n & ale & ~cle;
  assign bus_dat   = wr_stb & ~ce_n & ~cle & ~ale;
  assign ignore_go = LARGE_PAGE && cmd_q == OP_READ_A && din == OP_READ_GO;

  // Address assembly, least-significant byte first
  assign addr_nx  = addr_q | (32'(din) << {acnt_q, 3'b000});
  assign cnt_nx   = acnt_q + 3'd1;
  assign row_nx   = addr_nx >> ASHIFT;
  assign row_ok   = row_nx < 32'(NPAGES);
  assign start_nx = SW'(addr_nx[ASHIFT-1:0]) + off_q;
  assign fire     = bus_adr && acnt_q < 3'd4 && cnt_nx == 3'(FIRE);
  assign rd_base  = AW'(row_nx) * AW'(PS) + AW'(start_nx);
  assign rd_len_nx = (row_ok && start_nx < SW'(PS)) ? LW'(SW'(PS) - start_nx) : '0;

  // Confirm handling
  assign conf_prog  = bus_cmd && din == OP_PROG_GO && cmd_q == OP_PROG && armed_q && !eng_busy;
  assign conf_erase = bus_cmd && din == OP_ERASE_GO && cmd_q == OP_ERASE && !eng_busy;
  assign eng_start  = (conf_prog | conf_erase) & wp_n;

  always_comb begin
    p_avail  = (prow_q < 32'(NPAGES) && pstart_q < SW'(PS)) ? LW'(SW'(PS) - pstart_q) : '0;
    p_cnt    = (plen_q < p_avail) ? plen_q : p_avail;
    p_base   = AW'(prow_q) * AW'(PS) + AW'(pstart_q);
    e_base   = AW'((int'(addr_q[AW-1:0]) / PAGES_PER_BLOCK) * BLK);
    eng_base = conf_erase ? e_base : p_base;
    if (conf_erase) eng_cnt = (addr_q < 32'(NPAGES)) ? CW'(BLK) : '0;
    else            eng_cnt = CW'(p_cnt);
  end

  assign status = {wp_n, eng_busy, 5'b00000, err_q};

  always_comb begin
    case (id_idx_q)
      2'd0:    id_byte = MFR_ID;
      2'd1:    id_byte = DEV_ID;
      2'd2:    id_byte = IDENT_FILL;
      default: id_byte = LARGE_PAGE ? IDENT_LARGE : IDENT_SMALL;
    endcase
  end

  assign buf_we = bus_dat && cmd_q == OP_PROG && armed_q && plen_q < LW'(PS);
  assign arr_re = rd_stb && !ce_n && src_q == SRC_ARRAY && rlen_q != '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= OP_READ_A;
      addr_q    <= '0;
      acnt_q    <= '0;
      off_q     <= '0;
      rptr_q    <= '0;
      rlen_q    <= '0;
      src_q     <= SRC_NONE;
      id_idx_q  <= '0;
      err_q     <= 1'b0;
      plen_q    <= '0;
      pstart_q  <= '0;
      prow_q    <= '0;
      armed_q   <= 1'b0;
      out_arr_q <= 1'b0;
      obyte_q   <= '0;
    end else begin
      if (bus_cmd && !ignore_go) begin
        addr_q  <= '0;
        acnt_q  <= '0;
        armed_q <= 1'b0;
        rlen_q  <= '0;
        src_q   <= (din == OP_STATUS) ? SRC_STATUS : SRC_NONE;
        case (din)
          OP_READ_A:     begin cmd_q <= OP_READ_A; off_q <= '0; end
          OP_READ_B:     begin cmd_q <= OP_READ_A; off_q <= SW'(256); end
          OP_READ_SPARE: begin cmd_q <= OP_READ_A; off_q <= SW'(PAGE_BYTES); end
          OP_RESET: begin
            cmd_q  <= OP_READ_A;
            off_q  <= '0;
            err_q  <= 1'b0;
            plen_q <= '0;
          end
          default: cmd_q <= din;
        endcase
        if ((conf_prog || conf_erase) && !wp_n) err_q <= 1'b1;
      end else if (bus_adr && acnt_q < 3'd4) begin
        addr_q <= addr_nx;
        acnt_q <= cnt_nx;
        if (cmd_q == OP_IDENT && cnt_nx == 3'd1) begin
          src_q    <= SRC_IDENT;
          id_idx_q <= '0;
        end
        if (fire && cmd_q == OP_READ_A) begin
          src_q  <= SRC_ARRAY;
          rptr_q <= rd_base;
          rlen_q <= rd_len_nx;
          off_q  <= '0;
        end
        if (fire && cmd_q == OP_PROG) begin
          armed_q  <= 1'b1;
          plen_q   <= '0;
          pstart_q <= start_nx;
          prow_q   <= row_nx;
          off_q    <= '0;
        end
      end else if (buf_we) begin
        plen_q <= plen_q + 1'b1;
      end

      if (rd_stb) begin
        if (arr_re) begin
          out_arr_q <= 1'b1;
          rptr_q    <= rptr_q + 1'b1;
          rlen_q    <= rlen_q - 1'b1;
        end else begin
          out_arr_q <= 1'b0;
          if (ce_n) obyte_q <= 8'h00;
          else begin
            case (src_q)
              SRC_IDENT:  obyte_q <= id_byte;
              SRC_STATUS: obyte_q <= status;
              default:    obyte_q <= 8'h00;
            endcase
            if (src_q == SRC_IDENT) begin
              if (id_idx_q == 2'd3) src_q <= SRC_NONE;
              else id_idx_q <= id_idx_q + 1'b1;
            end
          end
        end
      end
    end
  end

  assign dout = out_arr_q ? arr_q : obyte_q;

  nand_ram #(.DEPTH(PS), .AW(BW), .INIT(8'hFF)) u_pbuf (
    .clk(clk), .we(buf_we), .waddr(plen_q[BW-1:0]), .wdata(din),
    .re(buf_re), .raddr(buf_raddr), .q(buf_q)
  );

  nand_ram #(.DEPTH(DEPTH), .AW(AW), .INIT(8'hFF)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(arr_re), .raddr(rptr_q), .q(arr_q)
  );

  nand_commit_engine #(.AW(AW), .CW(CW), .BW(BW)) u_engine (
    .clk(clk), .rst(rst), .start(eng_start), .erase_mode(conf_erase),
    .base(eng_base), .count(eng_cnt), .buf_q(buf_q), .busy(eng_busy),
    .buf_re(buf_re), .buf_raddr(buf_raddr), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );
endmodule

// File: rtl/nand_flash_dev_chk.sv
module nand_flash_dev_chk (
  input logic        clk,
  input logic        rst,
  input logic        ce_n,
  input logic        cle,
  input logic        wp_n,
  input logic        wr_stb,
  input logic        rd_stb,
  input logic [7:0]  din,
  input logic [7:0]  dout,
  input logic        busy,
  input logic        err,
  input logic [31:0] rlen
);
  // R13
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(dout));

  // R2
  ce_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && ce_n) |=> dout == 8'h00);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_stb && !ce_n && cle && wp_n));

  // R9
  wp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wp_n && !busy) |=> !busy);

  // R9
  err_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> $past(!wp_n));

  // R11
  reset_err_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !ce_n && cle && din == 8'hFF) |=> !err);

  // R4
  read_count_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !wr_stb && !ce_n && rlen != 0) |=> rlen == $past(rlen) - 1);
endmodule

bind nand_flash_dev nand_flash_dev_chk u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .wp_n(wp_n),
  .wr_stb(wr_stb), .rd_stb(rd_stb), .din(din), .dout(dout),
  .busy(eng_busy), .err(err_q), .rlen(32'(rlen_q))
);

// File: tb/sim_nand_flash_dev.sv
module sim_nand_flash_dev;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce0_n = 1'b1, ce1_n = 1'b1;
  logic cle = 1'b0, ale = 1'b0, wp_n = 1'b1;
  logic wr_stb = 1'b0, rd_stb = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout0, dout1;
  int cur = 0;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  nand_flash_dev u0 (
    .clk(clk), .rst(rst), .ce_n(ce0_n), .cle(cle), .ale(ale), .wp_n(wp_n),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .din(din), .dout(dout0)
  );

  nand_flash_dev #(.LARGE_PAGE(1'b1), .MFR_ID(8'h2C), .DEV_ID(8'hF1)) u1 (
    .clk(clk), .rst(rst), .ce_n(ce1_n), .cle(cle), .ale(ale), .wp_n(wp_n),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .din(din), .dout(dout1)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic pick(input int d);
    ce0_n = (d != 0);
    ce1_n = (d != 1);
  endtask

  task automatic bus_wr(input logic c, input logic a, input logic [7:0] v);
    @(negedge clk);
    cle = c; ale = a; din = v; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] v); bus_wr(1'b1, 1'b0, v); endtask
  task automatic adr(input logic [7:0] v); bus_wr(1'b0, 1'b1, v); endtask
  task automatic dat(input logic [7:0] v); bus_wr(1'b0, 1'b0, v); endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    v = (cur == 1) ? dout1 : dout0;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rdchk(input string req, input logic [7:0] exp);
    logic [7:0] v;
    rd(v);
    chk(req, v, exp);
  endtask

  task automatic wait_idle(input string req);
    logic [7:0] v;
    cmd(8'h70);
    for (int n = 0; n < 3000; n++) begin
      rd(v);
      if (!v[6]) break;
    end
    chk(req, v & 8'h40, 8'h00);
  endtask

  task automatic t_reset;
    cur = 0; pick(0);
    rdchk("R1 idle read", 8'h00);
    cmd(8'h70);
    rdchk("R1 status", 8'h80);
  endtask

  task automatic t_blank;
    cmd(8'h00); adr(8'h00); adr(8'h01); adr(8'h00);
    for (int i = 0; i < 3; i++) rdchk("R12 erased", 8'hFF);
    repeat (3) @(negedge clk);
    chk("R13 hold", dout0, 8'hFF);
  endtask

  task automatic t_ident_small;
    cmd(8'h90); adr(8'h00);
    rdchk("R3 mfr", 8'hEC);
    rdchk("R3 dev", 8'h73);
    rdchk("R3 fill", 8'hA5);
    rdchk("R3 small", 8'hC0);
    rdchk("R3 after", 8'h00);
  endtask

  task automatic t_prog_read;
    cmd(8'h80); adr(8'h10); adr(8'h01); adr(8'h00);
    for (int i = 0; i < 20; i++) dat(pat(i));
    cmd(8'h10);
    cmd(8'h70);
    rdchk("R10 busy", 8'hC0);
    wait_idle("R10 done");
    cmd(8'h00); adr(8'h0F); adr(8'h01); adr(8'h00);
    rdchk("R7 before", 8'hFF);
    for (int i = 0; i < 20; i++) rdchk("R7 data", pat(i));
    rdchk("R7 after", 8'hFF);
  endtask

  task automatic t_spare;
    cmd(8'h50); adr(8'h00); adr(8'h01); adr(8'h00);
    for (int i = 0; i < 16; i++) rdchk("R5 spare", 8'hFF);
    rdchk("R4 end", 8'h00);
    cmd(8'h50); cmd(8'h80); adr(8'h00); adr(8'h00); adr(8'h00);
    for (int i = 0; i < 20; i++) dat(pat(100 + i));
    cmd(8'h10);
    wait_idle("R7 idle");
    cmd(8'h50); adr(8'h00); adr(8'h00); adr(8'h00);
    for (int i = 0; i < 16; i++) rdchk("R7 spare data", pat(100 + i));
    rdchk("R4 end spare", 8'h00);
    cmd(8'h00); adr(8'h00); adr(8'h01); adr(8'h00);
    rdchk("R7 no spill", 8'hFF);
    cmd(8'h00); adr(8'h00); adr(8'h07); adr(8'h00);
    rdchk("R4 out of range", 8'h00);
  endtask

  task automatic t_half;
    cmd(8'h01); cmd(8'h80); adr(8'h05); adr(8'h02); adr(8'h00);
    dat(8'hA1); dat(8'hB2); dat(8'hC3);
    cmd(8'h10);
    wait_idle("R5 idle");
    cmd(8'h01); adr(8'h04); adr(8'h02); adr(8'h00);
    rdchk("R5 half", 8'hFF);
    rdchk("R5 half", 8'hA1);
    rdchk("R5 half", 8'hB2);
    rdchk("R5 half", 8'hC3);
    rdchk("R5 half", 8'hFF);
    cmd(8'h01); cmd(8'h00); adr(8'h05); adr(8'h02); adr(8'h00);
    rdchk("R5 cleared", 8'hFF);
  endtask

  task automatic t_ce;
    cmd(8'h01); adr(8'h05); adr(8'h02); adr(8'h00);
    pick(2);
    rdchk("R2 ce high read", 8'h00);
    cmd(8'hFF);
    adr(8'h00);
    pick(0);
    rdchk("R2 no advance", 8'hA1);
    rdchk("R2 next", 8'hB2);
  endtask

  task automatic t_protect;
    wp_n = 1'b0;
    cmd(8'h70);
    rdchk("R9 status", 8'h00);
    cmd(8'h80); adr(8'h10); adr(8'h01); adr(8'h00);
    dat(8'hAA);
    cmd(8'h10);
    cmd(8'h70);
    rdchk("R9 error", 8'h01);
    cmd(8'h60); adr(8'h01); adr(8'h00); cmd(8'hD0);
    cmd(8'h00); adr(8'h10); adr(8'h01); adr(8'h00);
    rdchk("R9 kept", pat(0));
    wp_n = 1'b1;
    cmd(8'h70);
    rdchk("R9 released", 8'h81);
  endtask

  task automatic t_soft_reset;
    cmd(8'h00); adr(8'h10); adr(8'h01); adr(8'h00);
    rdchk("R11 pre", pat(0));
    cmd(8'hFF);
    rdchk("R11 cancel", 8'h00);
    cmd(8'h70);
    rdchk("R11 status", 8'h80);
  endtask

  task automatic t_erase;
    cmd(8'h60); adr(8'h01); adr(8'h00); cmd(8'hD0);
    cmd(8'h70);
    rdchk("R10 erase busy", 8'hC0);
    wait_idle("R8 idle");
    cmd(8'h00); adr(8'h10); adr(8'h01); adr(8'h00);
    rdchk("R8 page", 8'hFF);
    cmd(8'h50); adr(8'h00); adr(8'h00); adr(8'h00);
    rdchk("R8 spare", 8'hFF);
    cmd(8'h01); adr(8'h05); adr(8'h02); adr(8'h00);
    rdchk("R8 other block", 8'hA1);
  endtask

  task automatic t_large;
    cur = 1; pick(1);
    cmd(8'h90); adr(8'h00);
    rdchk("R3 mfr large", 8'h2C);
    rdchk("R3 dev large", 8'hF1);
    rdchk("R3 fill large", 8'hA5);
    rdchk("R3 large", 8'h15);
    cmd(8'h80); adr(8'h03); adr(8'h00); adr(8'h01); adr(8'h00);
    for (int i = 0; i < 4; i++) dat(pat(50 + i));
    cmd(8'h10);
    wait_idle("R7 large idle");
    cmd(8'h00); adr(8'h02); adr(8'h00); adr(8'h01); adr(8'h00);
    cmd(8'h30);
    rdchk("R6 first", 8'hFF);
    rdchk("R6 d0", pat(50));
    cmd(8'h30);
    rdchk("R6 d1", pat(51));
    rdchk("R6 d2", pat(52));
    rdchk("R6 d3", pat(53));
    rdchk("R6 tail", 8'hFF);
    cmd(8'h60); adr(8'h01); adr(8'h00); cmd(8'hD0);
    wait_idle("R8 large idle");
    cmd(8'h00); adr(8'h04); adr(8'h00); adr(8'h01); adr(8'h00);
    cmd(8'h30);
    rdchk("R8 large erased", 8'hFF);
    cur = 0; pick(0);
    cmd(8'h70);
    rdchk("R2 other device", 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_blank();
    t_ident_small();
    t_prog_read();
    t_spare();
    t_half();
    t_ce();
    t_protect();
    t_soft_reset();
    t_erase();
    t_large();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule